// File: doc/BRIEF.md
# Wake-Up Edge Detector with Acknowledge

This block watches 32 port pins, arranged as four ports of eight, together with one USB sense input, and raises a wake request when a qualifying edge shows up on any of them. Every input first passes through a synchroniser. It then reaches an edge detector whose polarity is programmable: a port pin can be set to rising or falling, and the USB input has a polarity control of its own. Port pins also have enable bits. A qualifying edge on an enabled pin sets a sticky bit in the port flag register. The same edge on a disabled pin sets a bit in a separate masked flag register and does not request wake-up. A USB edge sets the USB flag.

Software reads the flag registers to find out which source caused the wake-up. To acknowledge, it writes ones to the bits it wants cleared. Each such write produces a clear pulse one clock long, and that pulse resets only the selected bits. The register port is a simple single-cycle interface. Writes take effect on the clock edge where the write strobe is sampled, and read data is registered from the address.

Top module: `wake_detect_unit`

## Requirements
- R1: After reset every control register, the port flags, the masked flags and the USB flag read 0, and wake_o is low.
- R2: With polarity bit 0 (rising), a low-to-high change on an enabled pin sets the port flag bit of the same index. Pin index p*8+b maps to bit p*8+b of every 32-bit register. A high-to-low change on that pin sets nothing.
- R3: With polarity bit 1 (falling), a high-to-low change on an enabled pin sets its port flag bit, and a low-to-high change sets nothing.
- R4: The USB flag (address 4, bit 0) is set by a USB edge selected by the USB polarity bit (address 1, bit 0; 0 means rising, 1 means falling). The edge of the other direction is ignored.
- R5: A qualifying edge on a pin whose enable bit is 0 sets the matching masked flag bit (address 5). It does not set the port flag bit and does not raise wake_o.
- R6: wake_o is high exactly while any port flag bit or the USB flag is set. It rises on the same clock edge as the flag, three clocks after the input changes.
- R7: Writing to a flag register (address 3, 4 or 5) clears exactly the bits written as 1, on the clock edge after the write. Bits written as 0 keep their value.
- R8: If a qualifying edge lands in the same cycle as the clear pulse for its bit, the bit ends up set.
- R9: Register map by word address: 0 port polarity, 1 USB polarity, 2 port enable, 3 port flags, 4 USB flag, 5 masked flags. Addresses 0 to 2 read back what was written. Addresses 6 and 7 read 0. Read data appears one clock after the address.
- R10: Flags are sticky. A flag stays set after its input returns to the old level, and a register write never sets a flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous port pins, port A in bits 7:0 |
| usb_i | input | 1 | Asynchronous USB sense input |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for reg_addr_i |
| wake_o | output | 1 | Wake request |

## Verification
An input change is captured by two synchroniser flops and one edge-history flop, so the flag and wake_o change on the third rising edge after the change. The bench waits exactly that many edges and then samples on the falling edge. A register read returns data one edge after the address is applied. A flag write clears its bits one edge after the write edge, so the bench leaves one idle cycle after every write before it reads. For the case where an edge meets a clear, the write edge is placed on the same clock as the synchroniser output rising, which makes the clear pulse and the edge event share one cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PORT_POL  = 3'd0,
    A_USB_POL   = 3'd1,
    A_PORT_EN   = 3'd2,
    A_PORT_FLAG = 3'd3,
    A_USB_FLAG  = 3'd4,
    A_MASK_FLAG = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] pol_i,   // 0 rising, 1 falling
  output logic [W-1:0] evt_o
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[LAST];
      end
    end

    assign evt_o[g] = pol_i[g] ? (~chain_q[LAST] & prev_q)
                               : (chain_q[LAST] & ~prev_q);

    // R2 R3: an event needs a change between history and synchronised value
    assert_evt_change_R2: assert property (@(posedge clk) disable iff (rst)
      evt_o[g] |-> (chain_q[LAST] != prev_q));
  end
endmodule

// File: rtl/wake_flag_bank.sv
module wake_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // set has priority over the one-cycle clear pulse
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [PW-1:0]     wdata_i,
  input  logic [PW-1:0]     port_flag_i,
  input  logic              usb_flag_i,
  input  logic [PW-1:0]     mask_flag_i,
  output logic [PW-1:0]     port_pol_o,
  output logic              usb_pol_o,
  output logic [PW-1:0]     port_en_o,
  output logic [PW-1:0]     port_clr_o,
  output logic              usb_clr_o,
  output logic [PW-1:0]     mask_clr_o,
  output logic [PW-1:0]     rdata_o
);
  logic [PW-1:0] port_pol_q, port_en_q, port_clr_q, mask_clr_q, rdata_q;
  logic          usb_pol_q, usb_clr_q;
  logic          wr_port_flag, wr_usb_flag, wr_mask_flag;

  assign wr_port_flag = wr_i && (addr_i == A_PORT_FLAG);
  assign wr_usb_flag  = wr_i && (addr_i == A_USB_FLAG);
  assign wr_mask_flag = wr_i && (addr_i == A_MASK_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_pol_q <= '0;
      usb_pol_q  <= 1'b0;
      port_en_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_PORT_POL: port_pol_q <= wdata_i;
        A_USB_POL:  usb_pol_q  <= wdata_i[0];
        A_PORT_EN:  port_en_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // clear pulses: high for the single cycle after a flag write
  always_ff @(posedge clk) begin
    if (rst) begin
      port_clr_q <= '0;
      usb_clr_q  <= 1'b0;
      mask_clr_q <= '0;
    end else begin
      port_clr_q <= wr_port_flag ? wdata_i : '0;
      usb_clr_q  <= wr_usb_flag & wdata_i[0];
      mask_clr_q <= wr_mask_flag ? wdata_i : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (addr_i)
        A_PORT_POL:  rdata_q <= port_pol_q;
        A_USB_POL:   rdata_q <= {{(PW-1){1'b0}}, usb_pol_q};
        A_PORT_EN:   rdata_q <= port_en_q;
        A_PORT_FLAG: rdata_q <= port_flag_i;
        A_USB_FLAG:  rdata_q <= {{(PW-1){1'b0}}, usb_flag_i};
        A_MASK_FLAG: rdata_q <= mask_flag_i;
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign port_pol_o = port_pol_q;
  assign usb_pol_o  = usb_pol_q;
  assign port_en_o  = port_en_q;
  assign port_clr_o = port_clr_q;
  assign usb_clr_o  = usb_clr_q;
  assign mask_clr_o = mask_clr_q;
  assign rdata_o    = rdata_q;

  assert_pulse_port_R7: assert property (@(posedge clk) disable iff (rst)
    (port_clr_q != '0) |-> $past(wr_i && (addr_i == A_PORT_FLAG)));

  assert_pulse_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_clr_q != '0) |-> $past(wr_i && (addr_i == A_MASK_FLAG)));

  assert_pulse_usb_R7: assert property (@(posedge clk) disable iff (rst)
    usb_clr_q |-> $past(wr_i && (addr_i == A_USB_FLAG)));
endmodule

// File: rtl/wake_detect_unit.sv
module wake_detect_unit
  import wake_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]  pin_i,
  input  logic                                usb_i,
  input  logic [ADDR_W-1:0]                   reg_addr_i,
  input  logic                                reg_wr_i,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]  reg_wdata_i,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  reg_rdata_o,
  output logic                                wake_o
);
  localparam int PW = NUM_PORTS * PINS_PER_PORT;

  logic [PW-1:0] port_pol, port_en, port_clr, mask_clr;
  logic [PW-1:0] pin_evt, port_flag, mask_flag;
  logic          usb_pol, usb_clr, usb_evt, usb_flag;

  wake_regs #(.PW(PW)) regs_i (
    .clk(clk), .rst(rst),
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .port_flag_i(port_flag), .usb_flag_i(usb_flag), .mask_flag_i(mask_flag),
    .port_pol_o(port_pol), .usb_pol_o(usb_pol), .port_en_o(port_en),
    .port_clr_o(port_clr), .usb_clr_o(usb_clr), .mask_clr_o(mask_clr),
    .rdata_o(reg_rdata_o)
  );

  wake_edge_det #(.W(PW), .SYNC_STAGES(SYNC_STAGES)) pin_det_i (
    .clk(clk), .rst(rst), .raw_i(pin_i), .pol_i(port_pol), .evt_o(pin_evt)
  );

  wake_edge_det #(.W(1), .SYNC_STAGES(SYNC_STAGES)) usb_det_i (
    .clk(clk), .rst(rst), .raw_i(usb_i), .pol_i(usb_pol), .evt_o(usb_evt)
  );

  wake_flag_bank #(.W(PW)) port_bank_i (
    .clk(clk), .rst(rst), .set_i(pin_evt & port_en), .clr_i(port_clr),
    .flag_o(port_flag)
  );

  wake_flag_bank #(.W(PW)) mask_bank_i (
    .clk(clk), .rst(rst), .set_i(pin_evt & ~port_en), .clr_i(mask_clr),
    .flag_o(mask_flag)
  );

  wake_flag_bank #(.W(1)) usb_bank_i (
    .clk(clk), .rst(rst), .set_i(usb_evt), .clr_i(usb_clr),
    .flag_o(usb_flag)
  );

  assign wake_o = (|port_flag) | usb_flag;

  assert_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((port_flag & ~$past(port_flag) & ~$past(port_en)) == '0));

  assert_wake_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_o) |-> $past((port_clr != '0) || usb_clr));

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!wake_o && (mask_flag == '0)));
endmodule

// File: tb/wake_detect_unit_tb.sv
module wake_detect_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin = '0;
  logic        usb = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_detect_unit dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .usb_i(usb),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wake_o(wake)
  );

  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] en;
    logic [31:0] start;
    logic [31:0] fin;
    logic [31:0] exp_port;
    logic [31:0] exp_mask;
    logic        exp_wake;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'hFFFFFFFF, 32'h0, 32'h000000FF, 32'h000000FF, 32'h0, 1'b1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF0000, 32'h0000FFFF, 32'h0, 1'b1},
    '{32'h0, 32'h0000FFFF, 32'h0, 32'h00FF00FF, 32'h000000FF, 32'h00FF0000, 1'b1},
    '{32'h0F0F0F0F, 32'hFFFF0000, 32'h00FF00FF, 32'hFF00FF00, 32'hF00F0000, 32'h0000F00F, 1'b1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hAAAAAAAA, 32'h0, 32'h0, 1'b0},
    '{32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic clear_all();
    reg_write(3'd3, 32'hFFFFFFFF);
    reg_write(3'd5, 32'hFFFFFFFF);
    reg_write(3'd4, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 wake", {31'b0, wake}, 32'h0);
    for (int a = 0; a < 6; a++) begin
      reg_read(a[2:0], d);
      check("R1 reg", d, 32'h0);
    end

    // R9 readback and unmapped addresses
    reg_write(3'd0, 32'h12345678);
    reg_write(3'd2, 32'hA5A5A5A5);
    reg_write(3'd1, 32'h3);
    reg_write(3'd6, 32'hFFFFFFFF);
    reg_read(3'd0, d); check("R9 port pol", d, 32'h12345678);
    reg_read(3'd2, d); check("R9 enable", d, 32'hA5A5A5A5);
    reg_read(3'd1, d); check("R9 usb pol", d, 32'h1);
    reg_read(3'd6, d); check("R9 addr6", d, 32'h0);
    reg_read(3'd7, d); check("R9 addr7", d, 32'h0);
    reg_write(3'd1, 32'h0);

    // table of polarity / enable / pin patterns: R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      reg_write(3'd0, VECS[v].pol);
      reg_write(3'd2, VECS[v].en);
      pin = VECS[v].start;
      wait_cycles(4);
      clear_all();
      pin = VECS[v].fin;
      wait_cycles(4);
      check("R6 wake vec", {31'b0, wake}, {31'b0, VECS[v].exp_wake});
      reg_read(3'd3, d); check("R2 R3 port flags vec", d, VECS[v].exp_port);
      reg_read(3'd5, d); check("R5 masked flags vec", d, VECS[v].exp_mask);
    end

    // R7 partial clear of masked flags (all set by the last vector)
    reg_write(3'd5, 32'h0000FFFF);
    reg_read(3'd5, d); check("R7 masked partial clear", d, 32'hFFFF0000);
    pin = 32'h0;
    wait_cycles(4);
    clear_all();

    // R4 R6 USB rising with exact timing
    usb = 1'b1;
    wait_cycles(2);
    check("R6 wake not yet", {31'b0, wake}, 32'h0);
    wait_cycles(1);
    check("R6 wake on third edge", {31'b0, wake}, 32'h1);
    reg_read(3'd4, d); check("R4 usb rising", d, 32'h1);
    reg_write(3'd4, 32'h1);
    reg_read(3'd4, d); check("R7 usb clear", d, 32'h0);
    check("R6 wake low after clear", {31'b0, wake}, 32'h0);
    reg_write(3'd1, 32'h1);
    usb = 1'b0;
    wait_cycles(4);
    reg_read(3'd4, d); check("R4 usb falling", d, 32'h1);
    reg_write(3'd4, 32'h1);
    usb = 1'b1;
    wait_cycles(4);
    reg_read(3'd4, d); check("R4 usb rising ignored", d, 32'h0);
    check("R4 wake low", {31'b0, wake}, 32'h0);

    // R10 sticky and R7 partial clear of port flags
    reg_write(3'd0, 32'h0);
    reg_write(3'd2, 32'hFFFFFFFF);
    pin = 32'h3;
    wait_cycles(4);
    pin = 32'h0;
    wait_cycles(4);
    reg_read(3'd3, d); check("R10 sticky after return", d, 32'h3);
    reg_write(3'd3, 32'h0);
    reg_read(3'd3, d); check("R10 zero write no effect", d, 32'h3);
    reg_write(3'd3, 32'h1);
    reg_read(3'd3, d); check("R7 port partial clear", d, 32'h2);
    check("R6 wake still high", {31'b0, wake}, 32'h1);
    clear_all();

    // R8 edge coinciding with the clear pulse
    pin = 32'h8;
    wait_cycles(4);
    pin = 32'h0;
    wait_cycles(4);
    reg_read(3'd3, d); check("R8 setup", d, 32'h8);
    pin = 32'h8;
    @(posedge clk); @(negedge clk);
    reg_write(3'd3, 32'h8);
    reg_read(3'd3, d); check("R8 set wins over clear", d, 32'h8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule